// File: doc/BRIEF.md
# Converter Serial Register Access Engine

This block is the master side of a four-wire serial link to a delta-sigma converter. The lines are a select line, a serial clock, a data line toward the converter and a data line back from it. A host asks for one transaction at a time. There are three kinds. A register write sends a command byte and then 24 data bits. A register read sends a command byte and then clocks 24 bits back in. A port resynchronisation sends a long run of ones that ends in a single zero, which returns the converter's port to the state where it waits for a command. Every field is shifted most significant bit first.

After reset the engine waits out a start-up period, measured in serial clock periods, so that the converter's oscillator can start and its power-on reset can finish. Only after that does it take requests. The serial clock is made from the system clock. The half period is rounded up, so the serial clock never runs faster than the limit set by parameter. A static mode pin holds the select line low at all times, for wiring that has only three wires.

Requests come in through a valid/ready handshake. A request is taken in the cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low through the start-up wait and for the whole of a transaction, so a held request simply waits. Read results come out as a single-cycle `rd_valid` pulse with `rd_data`. That side has no back-pressure: the host must capture the word in that cycle.

Top module: `adcsp_engine`

## Requirements
- R1: From reset the select line is high, the serial clock and the data line toward the converter are low, and `req_ready` stays low until 2 × STARTUP_BITS serial half periods (2 × STARTUP_BITS × HALF system clocks) have elapsed.
- R2: A request is accepted only in a cycle with `req_valid` and `req_ready` both high. `req_ready` (and `busy`, its inverse) holds until that transaction ends, and a request presented meanwhile starts no transaction.
- R3: A write (`req_op` = 2'b00) sends 32 bits in one select-low window: `req_cmd`, then `req_wdata[23:16]`, `[15:8]` and `[7:0]`, each byte MSB first.
- R4: A read (`req_op` = 2'b01) sends the 8 command bits and then 24 more clock periods with the outgoing data line low. It samples the incoming line at each of those rising clock edges. The first bit sampled goes to `rd_data[23]`, and `rd_valid` pulses for one cycle when the transaction ends.
- R5: A resynchronisation (`req_op` = 2'b10 or 2'b11) sends SYNC_ONES ones followed by exactly one zero, for SYNC_ONES+1 clock periods in total; `req_cmd` and `req_wdata` are ignored.
- R6: The serial clock idles low. Each bit is a low half and then a high half, each HALF system clocks long, with HALF = ceil(CLK_HZ / (2 × SCLK_MAX_HZ)).
- R7: The outgoing data line changes only while the serial clock is low, so it is set up before every rising edge, and it is low whenever no transaction is in progress.
- R8: With `three_wire` = 0, the select line falls at the start of the first bit's low half and rises HALF system clocks after the last falling clock edge. No rising clock edge occurs while it is high.
- R9: With `three_wire` = 1 the select line stays low, including during transactions.
- R10: `rd_data` changes only in the cycle `rd_valid` pulses; writes and resynchronisations neither pulse `rd_valid` nor alter `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| three_wire | input | 1 | 1: select line held low permanently |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine can take a request |
| req_op | input | 2 | 00 write, 01 read, 1x resynchronise |
| req_cmd | input | 8 | Command byte |
| req_wdata | input | 24 | Write data, high byte first on the line |
| busy | output | 1 | Start-up wait or transaction in progress |
| rd_valid | output | 1 | One-cycle pulse with a completed read |
| rd_data | output | 24 | Last read word |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_sclk | output | 1 | Serial clock, idles low |
| adc_din | output | 1 | Serial data toward the converter |
| adc_dout | input | 1 | Serial data from the converter |

## Verification
The hardest case to reach is a request that arrives while a transaction is already running. The host has to hold `req_valid` high across the whole transaction and drop it in the same cycle that `req_ready` returns. The bench does exactly that. It then confirms that only one select window and one captured bit stream occurred. The incoming data path depends on alignment: the bench models a converter that moves to its next output bit on each falling clock edge, so a read returns the expected word only if the engine samples on the rising edges.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;
  localparam logic [1:0] OP_WRITE = 2'b00;
  localparam logic [1:0] OP_READ  = 2'b01;
  localparam int FRAME_BITS = 32;
  localparam int DATA_BITS  = 24;
  localparam int CMD_BITS   = 8;

  typedef enum logic [1:0] {
    S_BOOT = 2'd0,
    S_IDLE = 2'd1,
    S_BITS = 2'd2,
    S_TAIL = 2'd3
  } eng_state_t;
endpackage

// File: rtl/adcsp_tick.sv
module adcsp_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  generate
    if (HALF <= 1) begin : g_direct
      assign tick = en;
    end else begin : g_count
      localparam int CW = $clog2(HALF);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else if (!en) cnt <= '0;
        else if (cnt == CW'(HALF - 1)) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end
      assign tick = en && (cnt == CW'(HALF - 1));

      // R6: half periods span several clocks, so ticks never come back to back
      a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/adcsp_shift.sv
module adcsp_shift #(
  parameter int WORD = 32,
  parameter int RXW  = 24,
  parameter int BW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [WORD-1:0] load_word,
  input  logic [BW-1:0]   load_bits,
  input  logic            sync_mode,
  input  logic            run,
  input  logic            tick,
  input  logic            ser_in,
  output logic            sclk,
  output logic            ser_out,
  output logic            last,
  output logic [RXW-1:0]  rx
);
  logic [WORD-1:0] sr;
  logic [BW-1:0]   bits_left;
  logic            high_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '0;
      bits_left <= '0;
      high_ph   <= 1'b0;
      sclk      <= 1'b0;
      rx        <= '0;
    end else if (load) begin
      sr        <= load_word;
      bits_left <= load_bits;
      high_ph   <= 1'b0;
      sclk      <= 1'b0;
    end else if (run && tick) begin
      if (!high_ph) begin
        sclk    <= 1'b1;
        high_ph <= 1'b1;
        rx      <= {rx[RXW-2:0], ser_in};
      end else begin
        sclk      <= 1'b0;
        high_ph   <= 1'b0;
        sr        <= {sr[WORD-2:0], 1'b0};
        bits_left <= bits_left - 1'b1;
      end
    end
  end

  assign last    = run && tick && high_ph && (bits_left == BW'(1));
  assign ser_out = sync_mode ? (bits_left != BW'(1)) : sr[WORD-1];

  // R7: outgoing bit held steady through the high half of every clock
  a_r7_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(ser_out));
  // R6: a rising serial clock edge only happens while shifting
  a_r6_rise_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $past(run));
endmodule

// File: rtl/adcsp_engine.sv
module adcsp_engine #(
  parameter int CLK_HZ       = 8_000_000,
  parameter int SCLK_MAX_HZ  = 2_000_000,
  parameter int STARTUP_BITS = 2048,
  parameter int SYNC_ONES    = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        three_wire,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_op,
  input  logic [7:0]  req_cmd,
  input  logic [23:0] req_wdata,
  output logic        busy,
  output logic        rd_valid,
  output logic [23:0] rd_data,
  output logic        adc_cs_n,
  output logic        adc_sclk,
  output logic        adc_din,
  input  logic        adc_dout
);
  import adcsp_pkg::*;

  localparam int HALF       = (CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
  localparam int MAXBITS    = (SYNC_ONES + 1 > FRAME_BITS) ? SYNC_ONES + 1 : FRAME_BITS;
  localparam int BW         = $clog2(MAXBITS + 1);
  localparam int BOOT_TICKS = 2 * STARTUP_BITS;
  localparam int BOOTW      = $clog2(BOOT_TICKS + 1);

  eng_state_t             state;
  logic [BOOTW-1:0]       boot_cnt;
  logic                   txn_rd, txn_sync;
  logic                   tick, last, ser_bit, accept;
  logic [FRAME_BITS-1:0]  load_word;
  logic [BW-1:0]          load_bits;
  logic [DATA_BITS-1:0]   rx;

  assign req_ready = (state == S_IDLE);
  assign busy      = !req_ready;
  assign accept    = req_valid && req_ready;
  assign load_word = {req_cmd, (req_op == OP_READ) ? {DATA_BITS{1'b0}} : req_wdata};
  assign load_bits = req_op[1] ? BW'(SYNC_ONES + 1) : BW'(FRAME_BITS);

  adcsp_tick #(.HALF(HALF)) u_tick (
    .clk (clk), .rst_n (rst_n), .en (state != S_IDLE), .tick (tick)
  );

  adcsp_shift #(.WORD(FRAME_BITS), .RXW(DATA_BITS), .BW(BW)) u_shift (
    .clk (clk), .rst_n (rst_n), .load (accept), .load_word (load_word),
    .load_bits (load_bits), .sync_mode (txn_sync), .run (state == S_BITS),
    .tick (tick), .ser_in (adc_dout), .sclk (adc_sclk), .ser_out (ser_bit),
    .last (last), .rx (rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_BOOT;
      boot_cnt <= '0;
      txn_rd   <= 1'b0;
      txn_sync <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        S_BOOT: if (tick) begin
          if (boot_cnt == BOOTW'(BOOT_TICKS - 1)) state <= S_IDLE;
          else boot_cnt <= boot_cnt + 1'b1;
        end
        S_IDLE: if (accept) begin
          state    <= S_BITS;
          txn_rd   <= (req_op == OP_READ);
          txn_sync <= req_op[1];
        end
        S_BITS: if (last) state <= S_TAIL;
        S_TAIL: if (tick) begin
          state <= S_IDLE;
          if (txn_rd) begin
            rd_valid <= 1'b1;
            rd_data  <= rx;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign adc_cs_n = three_wire ? 1'b0 : (state == S_BOOT || state == S_IDLE);
  assign adc_din  = (state == S_BITS) ? ser_bit : 1'b0;

  // R8: clock rises only inside the select window in four-wire mode
  a_r8_rise_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(adc_sclk) && !three_wire) |-> !adc_cs_n);
  // R4: read completion is a single-cycle pulse
  a_r4_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  // R10: read word moves only together with its pulse
  a_r10_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));
  // R2: ready only drops because a request was presented
  a_r2_drop_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(req_valid));
  // R6: clock idles low between transactions
  a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !adc_sclk);
endmodule

// File: tb/sim_adcsp_engine.sv
module sim_adcsp_engine;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int STARTUP    = 2048;
  localparam int SYNC_ONES  = 128;
  localparam int NVEC       = 6;
  // {op, cmd, wdata, converter word}
  localparam logic [57:0] VEC [NVEC] = '{
    {2'b00, 8'h82, 24'h800000, 24'h000000},
    {2'b01, 8'h92, 24'h000000, 24'h800000},
    {2'b00, 8'h84, 24'hA5C3F1, 24'h000000},
    {2'b01, 8'h94, 24'hFFFFFF, 24'h5A0F3C},
    {2'b00, 8'hFF, 24'h000001, 24'h000000},
    {2'b01, 8'h01, 24'h123456, 24'hC00003}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic three_wire = 1'b0, req_valid = 1'b0, req_ready, busy, rd_valid;
  logic [1:0] req_op = '0;
  logic [7:0] req_cmd = '0;
  logic [23:0] req_wdata = '0, rd_data;
  logic adc_cs_n, adc_sclk, adc_din, adc_dout;
  logic [31:0] dev_src = '0;

  int checks = 0, errors = 0;

  // monitor state
  logic sclk_d = 1'b0, cs_d = 1'b1, busy_d = 1'b1, din_d = 1'b0;
  logic [63:0] cap = '0;
  int cap_n = 0, fall_cnt = 0, zeros = 0, rdv_n = 0, cs_fall = 0, cs_hi = 0;
  int hi_len = 0, lo_len = 0, txn_cnt = 0;
  int per_viol = 0, hold_viol = 0, idle_viol = 0;
  logic [23:0] rdv_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcsp_engine #(.CLK_HZ(8_000_000), .SCLK_MAX_HZ(2_000_000),
                 .STARTUP_BITS(STARTUP), .SYNC_ONES(SYNC_ONES)) u0 (
    .clk (clk), .rst_n (rst_n), .three_wire (three_wire),
    .req_valid (req_valid), .req_ready (req_ready), .req_op (req_op),
    .req_cmd (req_cmd), .req_wdata (req_wdata), .busy (busy),
    .rd_valid (rd_valid), .rd_data (rd_data), .adc_cs_n (adc_cs_n),
    .adc_sclk (adc_sclk), .adc_din (adc_din), .adc_dout (adc_dout)
  );

  // converter model: advances one bit on every falling serial clock edge
  assign adc_dout = (fall_cnt < 32) ? dev_src[31 - fall_cnt] : 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !busy_d) begin
        txn_cnt++;
        cap = '0; cap_n = 0; fall_cnt = 0; zeros = 0; rdv_n = 0; cs_hi = 0;
        cs_fall = (cs_d && !adc_cs_n) ? 1 : 0;
        lo_len = 1; hi_len = 0;
      end else begin
        if (cs_d && !adc_cs_n) cs_fall++;
        if (busy && adc_cs_n && !three_wire) cs_hi++;
        if (three_wire && adc_cs_n) cs_hi++;
        if (adc_sclk && !sclk_d) begin
          cap = {cap[62:0], adc_din}; cap_n++;
          if (!adc_din) zeros++;
          if (lo_len != HALF) per_viol++;
          hi_len = 1;
        end else if (!adc_sclk && sclk_d) begin
          fall_cnt++;
          if (hi_len != HALF) per_viol++;
          lo_len = 1;
        end else if (adc_sclk) hi_len++;
        else lo_len++;
        if (adc_sclk && sclk_d && adc_din != din_d) hold_viol++;
      end
      if (!busy && (adc_din || adc_sclk)) idle_viol++;
      if (rd_valid) begin rdv_n++; rdv_data = rd_data; end
    end
    sclk_d = adc_sclk; cs_d = adc_cs_n; busy_d = busy; din_d = adc_din;
  end

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic run_txn(input logic [1:0] op, input logic [7:0] cmd,
                         input logic [23:0] wd, input logic [23:0] dw);
    dev_src = {8'h5A, dw};
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_cmd = cmd; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_frame(input logic [1:0] op, input logic [7:0] cmd,
                             input logic [23:0] wd, input logic [23:0] dw, input string tag);
    if (op == 2'b00) begin
      chk(cap_n == 32 && cap[31:0] == {cmd, wd}, {tag, " R3 write stream"}, cap[31:0], {cmd, wd});
      chk(rdv_n == 0, {tag, " R10 no pulse on write"}, rdv_n, 0);
    end else begin
      chk(cap_n == 32 && cap[31:0] == {cmd, 24'h0}, {tag, " R4 read command and idle data"},
          cap[31:0], {cmd, 24'h0});
      chk(rdv_n == 1 && rdv_data == dw, {tag, " R4 read word"}, rdv_data, dw);
    end
    if (!three_wire) chk(cs_fall == 1 && cs_hi == 0 && adc_cs_n, {tag, " R8 one select window"}, cs_fall, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired R1..R10 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int boot_clks;
    logic [23:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(adc_cs_n == 1 && adc_sclk == 0 && adc_din == 0 && req_ready == 0 && rd_valid == 0,
        "R1 reset outputs", {adc_cs_n, adc_sclk, adc_din, req_ready, rd_valid}, 5'b10000);
    rst_n = 1'b1;
    boot_clks = 0;
    while (!req_ready) begin @(negedge clk); boot_clks++; end
    chk(boot_clks >= 2*STARTUP*HALF - 1 && boot_clks <= 2*STARTUP*HALF + 2,
        "R1 start-up wait length", boot_clks, 2*STARTUP*HALF);
    chk(adc_sclk == 0 && adc_din == 0, "R1 no clocking during start-up", {adc_sclk, adc_din}, 0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      run_txn(VEC[i][57:56], VEC[i][55:48], VEC[i][47:24], VEC[i][23:0]);
      check_frame(VEC[i][57:56], VEC[i][55:48], VEC[i][47:24], VEC[i][23:0], $sformatf("vec%0d", i));
    end

    // R10: write after read leaves rd_data alone
    held = rd_data;
    run_txn(2'b00, 8'h84, 24'h0F0F0F, 24'h000000);
    chk(rd_data == held && rdv_n == 0, "R10 rd_data held across write", rd_data, held);

    // R5: resynchronisation, cmd and data ignored
    run_txn(2'b10, 8'h00, 24'h000000, 24'h000000);
    chk(cap_n == SYNC_ONES + 1, "R5 resync length", cap_n, SYNC_ONES + 1);
    chk(zeros == 1 && cap[0] == 1'b0, "R5 single trailing zero", zeros, 1);
    chk(rd_data == held && rdv_n == 0, "R10 rd_data held across resync", rd_data, held);
    run_txn(2'b11, 8'hFF, 24'hFFFFFF, 24'h000000);
    chk(cap_n == SYNC_ONES + 1 && zeros == 1 && cap[0] == 1'b0, "R5 resync op 11 ignores fields", cap_n, SYNC_ONES + 1);

    // R2: request held through a busy transaction starts nothing extra
    begin
      int t0;
      t0 = txn_cnt;
      dev_src = {8'h00, 24'h000000};
      @(negedge clk);
      req_op = 2'b00; req_cmd = 8'hC3; req_wdata = 24'h3C3C3C; req_valid = 1'b1;
      @(negedge clk);
      req_op = 2'b01; req_cmd = 8'h11; req_wdata = 24'h777777;
      while (busy) @(negedge clk);
      req_valid = 1'b0;
      repeat (4*HALF) @(negedge clk);
      chk(txn_cnt == t0 + 1, "R2 one transaction while request held", txn_cnt - t0, 1);
      chk(cap_n == 32 && cap[31:0] == {8'hC3, 24'h3C3C3C}, "R2 stream from accepted request only",
          cap[31:0], {8'hC3, 24'h3C3C3C});
      chk(req_ready == 1 && adc_cs_n == 1, "R2 idle afterwards", {req_ready, adc_cs_n}, 2'b11);
    end

    // R9: three-wire read
    three_wire = 1'b1;
    @(negedge clk);
    chk(adc_cs_n == 0, "R9 select low when idle", adc_cs_n, 0);
    run_txn(2'b01, 8'h94, 24'h0, 24'hA1B2C3);
    chk(cs_hi == 0 && adc_cs_n == 0, "R9 select low throughout", cs_hi, 0);
    chk(rdv_n == 1 && rdv_data == 24'hA1B2C3, "R9 R4 three-wire read word", rdv_data, 24'hA1B2C3);
    three_wire = 1'b0;
    @(negedge clk);

    // R6 / R7 global monitors
    chk(per_viol == 0, "R6 half period length", per_viol, 0);
    chk(hold_viol == 0, "R7 data stable while clock high", hold_viol, 0);
    chk(idle_viol == 0, "R7 data and clock low when idle", idle_viol, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule